// File: doc/BRIEF.md
# DMA Transfer Address Stepper With In-Page Wrap

This block holds the current address of a DMA transfer and moves it by one transfer each time it is told to. A transfer is either one byte (narrow mode) or one 16-bit word (wide mode). The address moves up or down. The page portion at the top of the address is never touched by stepping. When the stepping part runs past its end, it wraps around inside the same page. It does not carry into, or borrow from, the page bits.

A load strobe writes a new 24-bit address. On the same edge it captures the width mode and the direction, and the following steps use them. In narrow mode the page is 64K: bits 15:0 step and bits 23:16 stay fixed. In wide mode the page is 128K: bits 16:1 form a word counter that steps by one, bits 23:17 stay fixed, and bit 0 keeps the value it was loaded with. Reset puts the block into narrow mode, counting up from address zero.

Top module: `dma_page_addr`

## Requirements
- R1: After reset the address is 000000h, the mode is narrow and the direction is up, so a step with no load in between gives 000001h.
- R2: With `load_en` high, the address takes `load_addr` on the next rising clock edge. On the same edge the mode is captured from `wide_mode` (1 = 16-bit, 0 = 8-bit) and the direction from `count_down` (1 = decrement, 0 = increment).
- R3: When `load_en` and `step_en` are both high in the same cycle, the load wins and the step has no effect.
- R4: A narrow-mode step up adds one to bits 15:0 modulo 2^16 and keeps bits 23:16, so 01FFFFh becomes 010000h.
- R5: A narrow-mode step down subtracts one from bits 15:0 modulo 2^16 and keeps bits 23:16, so 020000h becomes 02FFFFh.
- R6: A wide-mode step up adds one to bits 16:1 modulo 2^16 and keeps bits 23:17 and bit 0, so 01FFFEh becomes 000000h.
- R7: A wide-mode step down subtracts one from bits 16:1 modulo 2^16 and keeps bits 23:17 and bit 0, so 020000h becomes 03FFFEh.
- R8: In a cycle with neither `load_en` nor `step_en`, the address does not change.
- R9: In wide mode, bit 0 keeps its loaded value through any number of steps, so 01FFFFh stepped up becomes 000001h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Load a new address, mode and direction |
| load_addr | input | 24 | Address to load |
| wide_mode | input | 1 | Mode captured on load: 1 = 16-bit, 0 = 8-bit |
| count_down | input | 1 | Direction captured on load: 1 = decrement, 0 = increment |
| step_en | input | 1 | Advance the address by one transfer |
| addr | output | 24 | Current transfer address |

## Verification
The bench targets the wrap points at both ends of each page and in both modes. A design that carried into the page would step 01FFFFh to 020000h. A design that borrowed from the page would step 020000h to 01FFFFh. A wide-mode design that stepped a 16-bit field starting at bit 0 would leave 01FFFEh at 01FFFFh instead of wrapping it to 000000h. Odd loaded addresses in wide mode expose a design that drops or moves bit 0. A load issued together with a step exposes a design that lets the step win or applies both. Long random runs compare every cycle against an integer model, which also shows any address drift in idle cycles.

// File: rtl/dma_page_addr.sv
module dma_page_addr #(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wide_mode,
  input  logic              count_down,
  input  logic              step_en,
  output logic [ADDR_W-1:0] addr
);
  localparam int WIDE_TOP = OFS_W;

  logic [ADDR_W-1:0] addr_q;
  logic              wide_q;
  logic              down_q;
  logic [OFS_W-1:0]  byte_ofs, word_ofs, byte_nxt, word_nxt;
  logic [ADDR_W-1:0] step_val;

  assign byte_ofs = addr_q[OFS_W-1:0];
  assign word_ofs = addr_q[WIDE_TOP:1];
  assign byte_nxt = down_q ? byte_ofs - 1'b1 : byte_ofs + 1'b1;
  assign word_nxt = down_q ? word_ofs - 1'b1 : word_ofs + 1'b1;

  always_comb begin
    step_val = addr_q;
    if (wide_q) step_val[WIDE_TOP:1] = word_nxt;
    else        step_val[OFS_W-1:0]  = byte_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wide_q <= 1'b0;
      down_q <= 1'b0;
    end else if (load_en) begin
      addr_q <= load_addr;
      wide_q <= wide_mode;
      down_q <= count_down;
    end else if (step_en) begin
      addr_q <= step_val;
    end
  end

  assign addr = addr_q;

  assert_load_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> addr == $past(load_addr));

  assert_load_beats_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && step_en) |=> addr == $past(load_addr));

  assert_narrow_page_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && step_en && !wide_q) |=> addr[ADDR_W-1:OFS_W] == $past(addr[ADDR_W-1:OFS_W]));

  assert_narrow_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && step_en && !wide_q && down_q) |=>
      addr[OFS_W-1:0] == $past(addr[OFS_W-1:0]) - 1'b1);

  assert_wide_page_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && step_en && wide_q) |=> addr[ADDR_W-1:WIDE_TOP+1] == $past(addr[ADDR_W-1:WIDE_TOP+1]));

  assert_wide_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && step_en && wide_q && down_q) |=>
      addr[WIDE_TOP:1] == $past(addr[WIDE_TOP:1]) - 1'b1);

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(addr));

  assert_bit0_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && step_en && wide_q) |=> addr[0] == $past(addr[0]));
endmodule

// File: tb/test_dma_page_addr.sv
module test_dma_page_addr;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [23:0] load_addr = '0;
  logic        wide_mode = 1'b0;
  logic        count_down = 1'b0;
  logic        step_en = 1'b0;
  logic [23:0] addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m_addr = 0;
  bit m_wide = 0;
  bit m_down = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_page_addr i_dma_page_addr (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .wide_mode(wide_mode), .count_down(count_down), .step_en(step_en), .addr(addr)
  );

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(addr) != exp) begin
      errors++;
      $display("FAIL %s actual %06h expected %06h", req, addr, exp);
    end
  endtask

  task automatic model_step();
    int ofs;
    if (!m_wide) begin
      ofs = m_addr % 65536;
      ofs = m_down ? (ofs + 65535) % 65536 : (ofs + 1) % 65536;
      m_addr = (m_addr / 65536) * 65536 + ofs;
    end else begin
      ofs = (m_addr / 2) % 65536;
      ofs = m_down ? (ofs + 65535) % 65536 : (ofs + 1) % 65536;
      m_addr = (m_addr / 131072) * 131072 + ofs * 2 + (m_addr % 2);
    end
  endtask

  task automatic cyc(input bit ld, input int val, input bit w, input bit d,
                     input bit st, input string req);
    @(negedge clk);
    load_en = ld; load_addr = val[23:0]; wide_mode = w; count_down = d; step_en = st;
    @(posedge clk);
    #1;
    if (ld) begin m_addr = val % 16777216; m_wide = w; m_down = d; end
    else if (st) model_step();
    check(req, m_addr);
  endtask

  task automatic corner(input int start, input bit w, input bit d, input int exp,
                        input string req);
    cyc(1, start, w, d, 0, "R2");
    cyc(0, 0, 0, 0, 1, req);
    checks++;
    if (int'(addr) != exp) begin
      errors++;
      $display("FAIL %s actual %06h expected %06h", req, addr, exp);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 3);
    #1;
    check("R1", 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 1, "R1");
    check("R1", 1);
    cyc(0, 0, 0, 0, 0, "R8");
    check("R8", 1);

    corner('h01FFFF, 0, 0, 'h010000, "R4");
    corner('h020000, 0, 1, 'h02FFFF, "R5");
    corner('h01FFFE, 1, 0, 'h000000, "R6");
    corner('h020000, 1, 1, 'h03FFFE, "R7");
    corner('h01FFFF, 1, 0, 'h000001, "R9");
    corner('h020001, 1, 1, 'h03FFFF, "R9");
    corner('hABFFFF, 0, 0, 'hAB0000, "R4");

    cyc(1, 'h123456, 0, 0, 0, "R2");
    cyc(1, 'h00FF00, 1, 1, 1, "R3");
    check("R3", 'h00FF00);
    cyc(0, 0, 0, 0, 1, "R7");
    check("R7", 'h00FEFE);
    cyc(0, 0, 0, 0, 0, "R8");
    check("R8", 'h00FEFE);

    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      int v = int'($urandom_range(0, 16777215));
      if (r < 8)       cyc(1, v, $urandom_range(0, 1), $urandom_range(0, 1), 0, "R2");
      else if (r < 12) cyc(1, v, $urandom_range(0, 1), $urandom_range(0, 1), 1, "R3");
      else if (r < 20) cyc(0, v, $urandom_range(0, 1), $urandom_range(0, 1), 0, "R8");
      else if (r < 60) cyc(0, v, $urandom_range(0, 1), $urandom_range(0, 1), 1,
                           m_wide ? "R6" : "R4");
      else if (r < 64) cyc(1, (v & 'hFE0000) | (r[0] ? 'h1FFFF : 0), 1, r[1], 0, "R2");
      else if (r < 68) cyc(1, (v & 'hFF0000) | (r[0] ? 'hFFFF : 0), 0, r[1], 0, "R2");
      else             cyc(0, v, 0, 0, 1, m_wide ? (m_down ? "R7" : "R6")
                                                 : (m_down ? "R5" : "R4"));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule